// File: doc/BRIEF.md
# Windowed Scan BIST Sequencer

This block runs logic self-test on one scan chain. For every test it fills the chain from a pseudo-random scan-input generator, steps a second generator that drives the primary inputs, and pulses the functional capture clock for one cycle. It then folds the primary-output response into a multiple-input signature register. The bits that leave the chain go into a serial signature register on the same shift cycles that load the next pattern. After the last test, a flush of one chain length empties the final responses into the serial register.

The run is divided into windows of a fixed number of tests. Each window has its own cumulative expected signature pair, which arrives on flat input buses indexed by window number. In normal mode the run goes to the end and makes one comparison. In diagnostic mode the sequencer compares at every window boundary. On a match it waits for a resume pulse. On a mismatch it stops and records that window. A plain-shift setting turns the signature registers into simple observation registers, so single pattern responses can be seen. A start pulse can also begin mid-run from any window once the matching generator, compactor and chain states have been supplied.

Top module: `lbist_window_seq`

## Requirements
- R1: Each test begins with exactly CHAIN_LEN cycles with `scan_shift` high. In each of those cycles `scan_in` equals bit 0 of the scan generator, and the generator then steps once. A step from state s is (s >> 1) XOR (SI_TAPS when s[0] is 1, else 0). The generator takes `seed_si` when a start is accepted.
- R2: After the shift cycles, the input generator steps exactly once, using the same rule with PI_TAPS. `pi_vec` shows its state and stays unchanged during shift cycles. The generator takes `seed_pi` on an accepted start.
- R3: The cycle after the input step has `cap_pulse` high for one cycle. `cap_pulse` is never high at the same time as `scan_shift`.
- R4: In the cycle after the capture, the compactor becomes step(state, MISR_TAPS) XOR `po_vec`. This is its only update per test. It takes `seed_misr` on an accepted start.
- R5: On every shift cycle the serial register becomes step(state, SISR_TAPS) XOR (`scan_out` placed in its top bit). The previous test's unload therefore shares cycles with the next load. After the last test of the last window there are CHAIN_LEN more shift cycles with `scan_in` at 0, and the scan generator does not step. The register takes `seed_sisr` on an accepted start.
- R6: In normal mode (`diag_mode` low at start) the run never pauses. Only the final signatures are compared, against entry NUM_WIN-1, so the entries for earlier windows have no effect on `fail`.
- R7: In diagnostic mode, after the last test of each window the signatures are compared with that window's entry (bits w*width upward on each expected bus). On a match the block raises `paused` and holds until `resume`. On a mismatch it goes straight to `done`, and `win_idx` stays on the failing window.
- R8: `fail` is sticky. `fail_win` records the first mismatching window. An accepted start clears both.
- R9: With `plain_mode` high at start, the compactor loads `po_vec` directly and the serial register shifts right with `scan_out` entering its top bit. No comparison is made, so `fail` stays low. Windows still pause in diagnostic mode.
- R10: A start is accepted when the block is idle, paused or done. It loads every seed and sets `win_idx` to `start_win` and `test_idx` to 0.
- R11: After reset the block is idle: `busy`, `paused`, `done`, `fail`, `scan_shift` and `cap_pulse` are all low.
- R12: `win_idx` stays below NUM_WIN and `test_idx` stays below TESTS_PER_WIN. `done` excludes `busy`, `paused`, `scan_shift` and `cap_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart a run |
| start_win | input | WIN_W | Window index the run begins at |
| diag_mode | input | 1 | Compare and pause at every window end |
| plain_mode | input | 1 | Signature registers act as plain shift/capture registers |
| resume | input | 1 | Leave a window pause |
| seed_si | input | SI_W | Scan generator seed |
| seed_pi | input | PI_W | Input generator seed |
| seed_misr | input | PO_W | Output compactor seed |
| seed_sisr | input | SISR_W | Serial signature seed |
| exp_misr_flat | input | NUM_WIN*PO_W | Expected compactor value per window |
| exp_sisr_flat | input | NUM_WIN*SISR_W | Expected serial signature per window |
| scan_in | output | 1 | Serial data into the chain |
| scan_shift | output | 1 | Chain shift enable |
| scan_out | input | 1 | Serial data out of the chain |
| pi_vec | output | PI_W | Pseudo-random primary input vector |
| cap_pulse | output | 1 | Functional capture clock enable |
| po_vec | input | PO_W | Primary output response |
| misr_sig | output | PO_W | Output compactor state |
| sisr_sig | output | SISR_W | Serial signature state |
| win_idx | output | WIN_W | Current window |
| test_idx | output | TST_W | Test within the window |
| busy | output | 1 | Run in progress |
| paused | output | 1 | Halted at a window boundary |
| done | output | 1 | Run finished or stopped on a mismatch |
| fail | output | 1 | Sticky signature mismatch |
| fail_win | output | WIN_W | First mismatching window |

## Verification
On every shift cycle, the serial register takes in the response the chain captured for the previous test while the same edge loads the next pattern bit. At the window's end the final unload instead coincides with the flush. A bench-side chain model makes its capture depend on its own contents. The serial signature matches the bench's independent model only if each absorbed bit is the chain bit present before that edge's shift. Any off-by-one between unload and load, or a missing or extra flush cycle, changes the signature at the next pause or at the end of the run.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PIADV,
    ST_CAPT,
    ST_COMP,
    ST_WEND,
    ST_HOLD,
    ST_FLUSH,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/lbist_lfsr_reg.sv
module lbist_lfsr_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = '0,
  parameter int PLAIN_CAPTURE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  input  logic         plain,
  input  logic [W-1:0] inject,
  output logic [W-1:0] q
);

  logic [W-1:0] lfsr_nxt;
  logic [W-1:0] plain_nxt;
  logic [W-1:0] q_d;

  // Galois step with parallel injection
  always_comb begin
    lfsr_nxt = (q >> 1) ^ (q[0] ? TAPS : '0) ^ inject;
  end

  generate
    if (PLAIN_CAPTURE != 0) begin : g_plain_cap
      assign plain_nxt = inject;
    end else begin : g_plain_shift
      assign plain_nxt = (q >> 1) ^ inject;
    end
  endgenerate

  always_comb begin
    q_d = q;
    if (seed_load) begin
      q_d = seed;
    end else if (adv) begin
      q_d = plain ? plain_nxt : lfsr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/lbist_win_cmp.sv
module lbist_win_cmp #(
  parameter int NUM_WIN = 4,
  parameter int MISR_W  = 8,
  parameter int SISR_W  = 16,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      check,
  input  logic [WIN_W-1:0]          win,
  input  logic [MISR_W-1:0]         misr,
  input  logic [SISR_W-1:0]         sisr,
  input  logic [NUM_WIN*MISR_W-1:0] exp_misr_flat,
  input  logic [NUM_WIN*SISR_W-1:0] exp_sisr_flat,
  output logic                      mismatch,
  output logic                      fail,
  output logic [WIN_W-1:0]          fail_win
);

  logic [MISR_W-1:0] exp_misr;
  logic [SISR_W-1:0] exp_sisr;
  logic              fail_d;
  logic [WIN_W-1:0]  fail_win_d;

  always_comb begin
    exp_misr = exp_misr_flat[win*MISR_W +: MISR_W];
    exp_sisr = exp_sisr_flat[win*SISR_W +: SISR_W];
    mismatch = (misr != exp_misr) || (sisr != exp_sisr);
  end

  always_comb begin
    fail_d     = fail;
    fail_win_d = fail_win;
    if (clear) begin
      fail_d     = 1'b0;
      fail_win_d = '0;
    end else if (check && mismatch && !fail) begin
      fail_d     = 1'b1;
      fail_win_d = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      fail_win <= '0;
    end else begin
      fail     <= fail_d;
      fail_win <= fail_win_d;
    end
  end

endmodule

// File: rtl/lbist_seq_ctrl.sv
module lbist_seq_ctrl
  import lbist_pkg::*;
#(
  parameter int CHAIN_LEN     = 8,
  parameter int TESTS_PER_WIN = 4,
  parameter int NUM_WIN       = 4,
  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int TST_W = (TESTS_PER_WIN > 1) ? $clog2(TESTS_PER_WIN) : 1,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] start_win,
  input  logic             diag_mode,
  input  logic             plain_mode,
  input  logic             resume,
  input  logic             mismatch,
  output logic             seed_load,
  output logic             si_adv,
  output logic             pi_adv,
  output logic             misr_adv,
  output logic             sisr_adv,
  output logic             cap,
  output logic             check,
  output logic             plain_q,
  output logic [WIN_W-1:0] win_q,
  output logic [TST_W-1:0] test_q,
  output logic             busy,
  output logic             paused,
  output logic             done
);

  seq_state_t       state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [TST_W-1:0] test_d;
  logic [WIN_W-1:0] win_d;
  logic             diag_q, diag_d;
  logic             plain_d;
  logic             start_ok;
  logic             last_bit, last_test, last_win;
  logic [WIN_W-1:0] win_start;

  always_comb begin
    last_bit  = (bit_q == BIT_W'(CHAIN_LEN - 1));
    last_test = (test_q == TST_W'(TESTS_PER_WIN - 1));
    last_win  = (win_q == WIN_W'(NUM_WIN - 1));
    start_ok  = start && ((state_q == ST_IDLE) || (state_q == ST_HOLD) ||
                          (state_q == ST_DONE));
    win_start = (int'(start_win) < NUM_WIN) ? start_win : WIN_W'(NUM_WIN - 1);
  end

  // Strobes decoded from the state
  always_comb begin
    seed_load = start_ok;
    si_adv    = (state_q == ST_LOAD);
    sisr_adv  = (state_q == ST_LOAD) || (state_q == ST_FLUSH);
    pi_adv    = (state_q == ST_PIADV);
    cap       = (state_q == ST_CAPT);
    misr_adv  = (state_q == ST_COMP);
    check     = (state_q == ST_WEND) && !plain_q && (diag_q || last_win);
    paused    = (state_q == ST_HOLD);
    done      = (state_q == ST_DONE);
    busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  end

  // Next-state and counter logic
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    test_d  = test_q;
    win_d   = win_q;
    diag_d  = diag_q;
    plain_d = plain_q;
    if (start_ok) begin
      state_d = ST_LOAD;
      bit_d   = '0;
      test_d  = '0;
      win_d   = win_start;
      diag_d  = diag_mode;
      plain_d = plain_mode;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          if (last_bit) begin
            bit_d   = '0;
            state_d = ST_PIADV;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        ST_PIADV: state_d = ST_CAPT;
        ST_CAPT:  state_d = ST_COMP;
        ST_COMP: begin
          if (!last_test) begin
            test_d  = test_q + 1'b1;
            state_d = ST_LOAD;
          end else if (last_win) begin
            state_d = ST_FLUSH;
          end else begin
            state_d = ST_WEND;
          end
        end
        ST_FLUSH: begin
          if (last_bit) begin
            bit_d   = '0;
            state_d = ST_WEND;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        ST_WEND: begin
          if (last_win) begin
            state_d = ST_DONE;
          end else if (diag_q) begin
            state_d = (check && mismatch) ? ST_DONE : ST_HOLD;
          end else begin
            win_d   = win_q + 1'b1;
            test_d  = '0;
            state_d = ST_LOAD;
          end
        end
        ST_HOLD: begin
          if (resume) begin
            win_d   = win_q + 1'b1;
            test_d  = '0;
            state_d = ST_LOAD;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      test_q  <= '0;
      win_q   <= '0;
      diag_q  <= 1'b0;
      plain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      test_q  <= test_d;
      win_q   <= win_d;
      diag_q  <= diag_d;
      plain_q <= plain_d;
    end
  end

endmodule

// File: rtl/lbist_window_seq.sv
module lbist_window_seq #(
  parameter int CHAIN_LEN     = 8,
  parameter int TESTS_PER_WIN = 4,
  parameter int NUM_WIN       = 4,
  parameter int SI_W          = 16,
  parameter int PI_W          = 8,
  parameter int PO_W          = 8,
  parameter int SISR_W        = 16,
  parameter logic [SI_W-1:0]   SI_TAPS   = 16'hB400,
  parameter logic [PI_W-1:0]   PI_TAPS   = 8'hB8,
  parameter logic [PO_W-1:0]   MISR_TAPS = 8'h8E,
  parameter logic [SISR_W-1:0] SISR_TAPS = 16'hD008,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int TST_W = (TESTS_PER_WIN > 1) ? $clog2(TESTS_PER_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [WIN_W-1:0]          start_win,
  input  logic                      diag_mode,
  input  logic                      plain_mode,
  input  logic                      resume,
  input  logic [SI_W-1:0]           seed_si,
  input  logic [PI_W-1:0]           seed_pi,
  input  logic [PO_W-1:0]           seed_misr,
  input  logic [SISR_W-1:0]         seed_sisr,
  input  logic [NUM_WIN*PO_W-1:0]   exp_misr_flat,
  input  logic [NUM_WIN*SISR_W-1:0] exp_sisr_flat,
  output logic                      scan_in,
  output logic                      scan_shift,
  input  logic                      scan_out,
  output logic [PI_W-1:0]           pi_vec,
  output logic                      cap_pulse,
  input  logic [PO_W-1:0]           po_vec,
  output logic [PO_W-1:0]           misr_sig,
  output logic [SISR_W-1:0]         sisr_sig,
  output logic [WIN_W-1:0]          win_idx,
  output logic [TST_W-1:0]          test_idx,
  output logic                      busy,
  output logic                      paused,
  output logic                      done,
  output logic                      fail,
  output logic [WIN_W-1:0]          fail_win
);

  logic            seed_load, si_adv, pi_adv, misr_adv, sisr_adv;
  logic            check, mismatch, plain_q;
  logic [SI_W-1:0] si_q;

  lbist_seq_ctrl #(
    .CHAIN_LEN    (CHAIN_LEN),
    .TESTS_PER_WIN(TESTS_PER_WIN),
    .NUM_WIN      (NUM_WIN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_win (start_win),
    .diag_mode (diag_mode),
    .plain_mode(plain_mode),
    .resume    (resume),
    .mismatch  (mismatch),
    .seed_load (seed_load),
    .si_adv    (si_adv),
    .pi_adv    (pi_adv),
    .misr_adv  (misr_adv),
    .sisr_adv  (sisr_adv),
    .cap       (cap_pulse),
    .check     (check),
    .plain_q   (plain_q),
    .win_q     (win_idx),
    .test_q    (test_idx),
    .busy      (busy),
    .paused    (paused),
    .done      (done)
  );

  lbist_lfsr_reg #(.W(SI_W), .TAPS(SI_TAPS), .PLAIN_CAPTURE(0)) u_si_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_load(seed_load),
    .seed     (seed_si),
    .adv      (si_adv),
    .plain    (1'b0),
    .inject   ('0),
    .q        (si_q)
  );

  lbist_lfsr_reg #(.W(PI_W), .TAPS(PI_TAPS), .PLAIN_CAPTURE(0)) u_pi_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_load(seed_load),
    .seed     (seed_pi),
    .adv      (pi_adv),
    .plain    (1'b0),
    .inject   ('0),
    .q        (pi_vec)
  );

  lbist_lfsr_reg #(.W(PO_W), .TAPS(MISR_TAPS), .PLAIN_CAPTURE(1)) u_misr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_load(seed_load),
    .seed     (seed_misr),
    .adv      (misr_adv),
    .plain    (plain_q),
    .inject   (po_vec),
    .q        (misr_sig)
  );

  lbist_lfsr_reg #(.W(SISR_W), .TAPS(SISR_TAPS), .PLAIN_CAPTURE(0)) u_sisr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_load(seed_load),
    .seed     (seed_sisr),
    .adv      (sisr_adv),
    .plain    (plain_q),
    .inject   ({scan_out, {(SISR_W-1){1'b0}}}),
    .q        (sisr_sig)
  );

  lbist_win_cmp #(
    .NUM_WIN(NUM_WIN),
    .MISR_W (PO_W),
    .SISR_W (SISR_W)
  ) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (seed_load),
    .check        (check),
    .win          (win_idx),
    .misr         (misr_sig),
    .sisr         (sisr_sig),
    .exp_misr_flat(exp_misr_flat),
    .exp_sisr_flat(exp_sisr_flat),
    .mismatch     (mismatch),
    .fail         (fail),
    .fail_win     (fail_win)
  );

  // Flush cycles shift without stepping the generator: feed zeros
  assign scan_shift = sisr_adv;
  assign scan_in    = si_adv ? si_q[0] : 1'b0;

endmodule

// File: rtl/lbist_window_seq_chk.sv
module lbist_window_seq_chk #(
  parameter int PI_W          = 8,
  parameter int NUM_WIN       = 4,
  parameter int TESTS_PER_WIN = 4,
  parameter int WIN_W         = 2,
  parameter int TST_W         = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             resume,
  input logic             scan_shift,
  input logic             cap_pulse,
  input logic [PI_W-1:0]  pi_vec,
  input logic             busy,
  input logic             paused,
  input logic             done,
  input logic             fail,
  input logic [WIN_W-1:0] fail_win,
  input logic [WIN_W-1:0] win_idx,
  input logic [TST_W-1:0] test_idx
);

  assert_shift_cap_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_shift && cap_pulse));

  assert_cap_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);

  assert_pi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_shift && $past(scan_shift)) |-> $stable(pi_vec));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_win)));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !resume && !start) |=> paused);

  assert_idx_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(win_idx) < NUM_WIN) && (int'(test_idx) < TESTS_PER_WIN));

  assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !paused && !scan_shift && !cap_pulse));

endmodule

bind lbist_window_seq lbist_window_seq_chk #(
  .PI_W         (PI_W),
  .NUM_WIN      (NUM_WIN),
  .TESTS_PER_WIN(TESTS_PER_WIN),
  .WIN_W        (WIN_W),
  .TST_W        (TST_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .resume    (resume),
  .scan_shift(scan_shift),
  .cap_pulse (cap_pulse),
  .pi_vec    (pi_vec),
  .busy      (busy),
  .paused    (paused),
  .done      (done),
  .fail      (fail),
  .fail_win  (fail_win),
  .win_idx   (win_idx),
  .test_idx  (test_idx)
);

// File: tb/lbist_window_seq_tb.sv
module lbist_window_seq_tb;

  localparam int CL  = 8;
  localparam int TPW = 4;
  localparam int NW  = 4;
  localparam logic [15:0] SI_T   = 16'hB400;
  localparam logic [7:0]  PI_T   = 8'hB8;
  localparam logic [7:0]  MISR_T = 8'h8E;
  localparam logic [15:0] SISR_T = 16'hD008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, diag_mode = 1'b0, plain_mode = 1'b0, resume = 1'b0;
  logic [1:0]  start_win = '0;
  logic [15:0] seed_si = '0, seed_sisr = '0;
  logic [7:0]  seed_pi = '0, seed_misr = '0;
  logic [7:0]  exp_m [NW];
  logic [15:0] exp_s [NW];
  logic [NW*8-1:0]  exp_misr_flat;
  logic [NW*16-1:0] exp_sisr_flat;
  logic        scan_in, scan_shift, cap_pulse, busy, paused, done, fail;
  logic [7:0]  pi_vec, po_vec, misr_sig;
  logic [15:0] sisr_sig;
  logic [1:0]  win_idx, test_idx, fail_win;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      exp_misr_flat[i*8 +: 8]   = exp_m[i];
      exp_sisr_flat[i*16 +: 16] = exp_s[i];
    end
  end

  // Functional circuit stand-in: one chain, capture mixes chain and inputs
  logic [7:0] ch = '0;
  logic       scan_out;
  assign scan_out = ch[7];
  assign po_vec   = ch ^ {pi_vec[3:0], pi_vec[7:4]};
  always @(posedge clk) begin
    if (scan_shift)     ch <= {ch[6:0], scan_in};
    else if (cap_pulse) ch <= {ch[6:0], ch[7]} ^ pi_vec;
  end

  lbist_window_seq #(
    .CHAIN_LEN(CL), .TESTS_PER_WIN(TPW), .NUM_WIN(NW),
    .SI_W(16), .PI_W(8), .PO_W(8), .SISR_W(16),
    .SI_TAPS(SI_T), .PI_TAPS(PI_T), .MISR_TAPS(MISR_T), .SISR_TAPS(SISR_T)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_win(start_win),
    .diag_mode(diag_mode), .plain_mode(plain_mode), .resume(resume),
    .seed_si(seed_si), .seed_pi(seed_pi), .seed_misr(seed_misr), .seed_sisr(seed_sisr),
    .exp_misr_flat(exp_misr_flat), .exp_sisr_flat(exp_sisr_flat),
    .scan_in(scan_in), .scan_shift(scan_shift), .scan_out(scan_out),
    .pi_vec(pi_vec), .cap_pulse(cap_pulse), .po_vec(po_vec),
    .misr_sig(misr_sig), .sisr_sig(sisr_sig), .win_idx(win_idx), .test_idx(test_idx),
    .busy(busy), .paused(paused), .done(done), .fail(fail), .fail_win(fail_win)
  );

  int n_checks = 0, n_fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference model built from the requirement text
  function automatic logic [15:0] st16(input logic [15:0] s, input logic [15:0] t);
    return (s >> 1) ^ (s[0] ? t : 16'h0);
  endfunction
  function automatic logic [7:0] st8(input logic [7:0] s, input logic [7:0] t);
    return (s >> 1) ^ (s[0] ? t : 8'h0);
  endfunction

  logic [15:0] m_si, m_sisr;
  logic [7:0]  m_pi, m_misr, m_ch;
  logic [7:0]  ex_m [NW];
  logic [15:0] ex_s [NW];
  logic [15:0] ws_si [NW], ws_sisr [NW];
  logic [7:0]  ws_pi [NW], ws_misr [NW], ws_ch [NW];

  task automatic model(input int w0, input bit pl);
    logic sout, sin;
    logic [7:0] po;
    for (int w = w0; w < NW; w++) begin
      ws_si[w] = m_si; ws_pi[w] = m_pi; ws_misr[w] = m_misr;
      ws_sisr[w] = m_sisr; ws_ch[w] = m_ch;
      for (int t = 0; t < TPW; t++) begin
        for (int b = 0; b < CL; b++) begin
          sin  = m_si[0];
          sout = m_ch[7];
          m_sisr = pl ? ((m_sisr >> 1) ^ {sout, 15'b0}) : (st16(m_sisr, SISR_T) ^ {sout, 15'b0});
          m_si = st16(m_si, SI_T);
          m_ch = {m_ch[6:0], sin};
        end
        m_pi = st8(m_pi, PI_T);
        m_ch = {m_ch[6:0], m_ch[7]} ^ m_pi;
        po   = m_ch ^ {m_pi[3:0], m_pi[7:4]};
        m_misr = pl ? po : (st8(m_misr, MISR_T) ^ po);
      end
      if (w == NW - 1) begin
        for (int b = 0; b < CL; b++) begin
          sout = m_ch[7];
          m_sisr = pl ? ((m_sisr >> 1) ^ {sout, 15'b0}) : (st16(m_sisr, SISR_T) ^ {sout, 15'b0});
          m_ch = {m_ch[6:0], 1'b0};
        end
      end
      ex_m[w] = m_misr;
      ex_s[w] = m_sisr;
    end
  endtask

  // Scoreboard
  typedef struct {
    bit          at_end;
    int          win;
    logic [7:0]  misr;
    logic [15:0] sisr;
    string       req;
  } sb_item_t;
  sb_item_t sbq[$];

  task automatic push(input bit at_end, input int w, input logic [7:0] m,
                      input logic [15:0] s, input string req);
    sb_item_t it;
    it.at_end = at_end; it.win = w; it.misr = m; it.sisr = s; it.req = req;
    sbq.push_back(it);
  endtask

  int n_shift = 0, n_cap = 0, n_pause = 0;
  logic pz = 1'b0, dz = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_shift) n_shift++;
      if (cap_pulse)  n_cap++;
      if ((paused && !pz) || (done && !dz)) begin
        if (paused && !pz) n_pause++;
        if (sbq.size() == 0) begin
          check(1'b0, "R7 unexpected stop", {30'b0, done, paused}, 0);
        end else begin
          sb_item_t it;
          it = sbq.pop_front();
          check(done == it.at_end, {it.req, " stop kind"}, done, it.at_end);
          check(int'(win_idx) == it.win, {it.req, " window"}, win_idx, it.win);
          check(misr_sig == it.misr, {it.req, " misr"}, misr_sig, it.misr);
          check(sisr_sig == it.sisr, {it.req, " sisr"}, sisr_sig, it.sisr);
        end
      end
      pz = paused;
      dz = done;
    end
  end

  logic [7:0]  g_m [NW];
  logic [15:0] g_s [NW];
  localparam logic [15:0] S_SI = 16'hACE1, S_SISR = 16'h0000;
  localparam logic [7:0]  S_PI = 8'h5A, S_MISR = 8'h00;

  task automatic kick(input int w0, input bit dg, input bit pl, input logic [15:0] ssi,
                      input logic [7:0] spi, input logic [7:0] sm, input logic [15:0] ss);
    @(negedge clk);
    start_win = w0[1:0]; diag_mode = dg; plain_mode = pl;
    seed_si = ssi; seed_pi = spi; seed_misr = sm; seed_sisr = ss;
    n_shift = 0; n_cap = 0; n_pause = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_to_done();
    while (!done) begin
      if (paused) begin
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
  endtask

  task automatic set_exp_gold();
    for (int i = 0; i < NW; i++) begin exp_m[i] = g_m[i]; exp_s[i] = g_s[i]; end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin exp_m[i] = '0; exp_s[i] = '0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !paused && !done && !fail, "R11 idle flags", {busy, paused, done, fail}, 0);
    check(!scan_shift && !cap_pulse, "R11 strobes low", {scan_shift, cap_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Golden reference from seeds with an empty chain
    m_si = S_SI; m_pi = S_PI; m_misr = S_MISR; m_sisr = S_SISR; m_ch = '0;
    model(0, 1'b0);
    for (int i = 0; i < NW; i++) begin g_m[i] = ex_m[i]; g_s[i] = ex_s[i]; end
    set_exp_gold();

    // R7 R1 R2 R4 R5: diagnostic run with matching signatures
    ch = '0;
    for (int w = 0; w < NW - 1; w++) push(1'b0, w, g_m[w], g_s[w], "R7 window pause");
    push(1'b1, NW - 1, g_m[NW-1], g_s[NW-1], "R5 final signature");
    kick(0, 1'b1, 1'b0, S_SI, S_PI, S_MISR, S_SISR);
    run_to_done();
    check(!fail, "R7 no fail on match", fail, 0);
    check(n_shift == CL * (NW * TPW + 1), "R1 R5 shift cycles incl flush", n_shift, CL * (NW * TPW + 1));
    check(n_cap == NW * TPW, "R3 one capture per test", n_cap, NW * TPW);
    check(n_pause == NW - 1, "R7 pause count", n_pause, NW - 1);

    // R6: normal mode ignores an intermediate entry
    ch = '0;
    exp_m[1] = g_m[1] ^ 8'h01;
    push(1'b1, NW - 1, g_m[NW-1], g_s[NW-1], "R6 normal end");
    kick(0, 1'b0, 1'b0, S_SI, S_PI, S_MISR, S_SISR);
    run_to_done();
    check(!fail, "R6 middle entry ignored", fail, 0);
    check(n_pause == 0, "R6 no pauses", n_pause, 0);

    // R8: normal mode with a wrong final entry
    ch = '0;
    set_exp_gold();
    exp_s[NW-1] = g_s[NW-1] ^ 16'h8000;
    push(1'b1, NW - 1, g_m[NW-1], g_s[NW-1], "R8 normal end");
    kick(0, 1'b0, 1'b0, S_SI, S_PI, S_MISR, S_SISR);
    run_to_done();
    check(fail, "R8 end mismatch flagged", fail, 1);
    check(fail_win == 2'(NW - 1), "R8 fail window", fail_win, NW - 1);

    // R7 R8: diagnostic stop at the first wrong window
    ch = '0;
    set_exp_gold();
    exp_m[1] = g_m[1] ^ 8'h40;
    exp_m[2] = g_m[2] ^ 8'h40;
    push(1'b0, 0, g_m[0], g_s[0], "R7 pause before fault");
    push(1'b1, 1, g_m[1], g_s[1], "R7 stop at fault");
    kick(0, 1'b1, 1'b0, S_SI, S_PI, S_MISR, S_SISR);
    run_to_done();
    check(fail && fail_win == 2'd1, "R8 first failing window", {fail, fail_win}, 3'b101);
    check(n_cap == 2 * TPW, "R7 halted after window", n_cap, 2 * TPW);

    // R10: restart from a pause into window 2 with its saved states
    ch = '0;
    set_exp_gold();
    push(1'b0, 0, g_m[0], g_s[0], "R10 first pause");
    push(1'b0, 2, g_m[2], g_s[2], "R10 restarted window");
    push(1'b1, NW - 1, g_m[NW-1], g_s[NW-1], "R10 restarted end");
    kick(0, 1'b1, 1'b0, S_SI, S_PI, S_MISR, S_SISR);
    while (!paused) @(negedge clk);
    ch = ws_ch[2];
    kick(2, 1'b1, 1'b0, ws_si[2], ws_pi[2], ws_misr[2], ws_sisr[2]);
    check(win_idx == 2'd2 && test_idx == 2'd0 && busy, "R10 restart indices",
          {win_idx, test_idx, busy}, 5'b10001);
    check(!fail, "R10 fail cleared", fail, 0);
    run_to_done();
    check(!fail, "R10 restarted run passes", fail, 0);

    // R9: plain registers, wrong expected values must not flag
    m_si = S_SI; m_pi = S_PI; m_misr = S_MISR; m_sisr = S_SISR; m_ch = '0;
    model(0, 1'b1);
    ch = '0;
    for (int i = 0; i < NW; i++) begin exp_m[i] = ~ex_m[i]; exp_s[i] = ~ex_s[i]; end
    for (int w = 0; w < NW - 1; w++) push(1'b0, w, ex_m[w], ex_s[w], "R9 plain pause");
    push(1'b1, NW - 1, ex_m[NW-1], ex_s[NW-1], "R9 plain end");
    kick(0, 1'b1, 1'b1, S_SI, S_PI, S_MISR, S_SISR);
    run_to_done();
    check(!fail, "R9 no compare in plain mode", fail, 0);
    check(sbq.size() == 0, "R7 all scoreboard items seen", sbq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule